// File: doc/BRIEF.md
# Write-Triggered Interrupt Mailbox Bank

This block holds a parameterized set of word-wide mailbox slots, each paired with one interrupt line. A source that writes a slot leaves a data word in it and raises the slot's interrupt line toward the target. The target then reads that same slot. The read returns the word and acknowledges the interrupt, which drops the line. The word remains in the slot after the read, so the mailbox carries one value from one source to the target without any further handshake.

Access uses a plain register port: a slot index, a write strobe, a read strobe, write data and registered read data. Write and read share one index. A write and a read issued in the same cycle therefore always target the same slot. Indices at or above the configured slot count match no slot.

Top module: `mbx_bank`

## Requirements
- R1: A write strobe to slot index i (i below NUM_BOXES) stores the write data in slot i and sets irq[i] high from the next clock edge.
- R2: A read strobe to slot index i drives the word held in slot i onto rd_data one cycle later, and drives irq[i] low from the next clock edge.
- R3: A slot's stored word and its interrupt line do not change while no access addresses that slot. A read also leaves the stored word in place, so a second read returns the same word.
- R4: When two writes hit the same slot in a row, the second word replaces the first with no error. A later read returns the second word, and the line stays high throughout.
- R5: A write and a read to the same slot in the same cycle leave irq high, because the write takes priority over the acknowledge. rd_data returns the word held before that cycle, and the new word is stored.
- R6: While rst_n is low at a clock edge, every stored word, every irq bit and rd_data are cleared to zero.
- R7: An access whose index is NUM_BOXES or higher is ignored. It stores nothing and sets or clears no line, and a read at such an index returns zero on rd_data.
- R8: rd_data keeps its last value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_idx | input | ADDR_W | Slot index shared by write and read |
| wr_stb | input | 1 | Write strobe: store the word and raise the line |
| rd_stb | input | 1 | Read strobe: return the word and acknowledge the line |
| wr_data | input | DATA_W | Word to store |
| rd_data | output | DATA_W | Registered read data, valid one cycle after rd_stb |
| irq | output | NUM_BOXES | One interrupt line per slot |

## Verification
The hardest case to reach from the ports is a write and an acknowledge meeting on one slot in the same cycle. The bench creates it by holding both strobes high on one index. It then checks that the line stays high, that rd_data carries the older word, and that a later read returns the newer word and finally drops the line. Out-of-range indices are tested at the first unused index and at the highest encodable index. A mid-run reset is also applied with a line raised and a word stored, and the bench checks that both are cleared.

// File: rtl/mbx_pkg.sv
// Package: mbx_pkg
// Shared types for the mailbox bank. It classifies the access that the
// decoder sees on the register port in one cycle.
// Assumes: nothing beyond IEEE 1800-2017.
package mbx_pkg;

    // Kind of access seen on the shared index in one cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_kind_t;

    // Builds the access kind from the two strobes
    function automatic acc_kind_t classify(input logic wr, input logic rd);
        return acc_kind_t'({rd, wr});
    endfunction

endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Turns the shared slot index and the two strobes into one-hot write-hit and
// read-hit vectors, plus a flag that says the index names an existing slot.
// Assumes: 2**ADDR_W >= NUM_BOXES. Purely combinational.
module mbx_decode #(
    parameter int NUM_BOXES = 8,
    parameter int ADDR_W    = 4
) (
    input  logic [ADDR_W-1:0]    acc_idx,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    output logic [NUM_BOXES-1:0] wr_hit,
    output logic [NUM_BOXES-1:0] rd_hit,
    output logic                 idx_ok
);
    import mbx_pkg::*;

    localparam logic [ADDR_W:0] SLOT_LIMIT = (ADDR_W+1)'(NUM_BOXES);

    acc_kind_t kind;

    // Classify the access once so that every slot compare shares it
    always_comb kind = classify(wr_stb, rd_stb);

    // Range check on the raw index
    always_comb idx_ok = ({1'b0, acc_idx} < SLOT_LIMIT);

    // One comparator per slot
    for (genvar g = 0; g < NUM_BOXES; g++) begin : g_cmp
        logic match;
        always_comb match = (acc_idx == ADDR_W'(g));
        always_comb wr_hit[g] = match && (kind == ACC_WRITE || kind == ACC_BOTH);
        always_comb rd_hit[g] = match && (kind == ACC_READ  || kind == ACC_BOTH);
    end

    // Decoder sanity: at most one slot hit, and none for an invalid index
    always_comb begin
        AST_WR_ONEHOT: assert ($onehot0(wr_hit));            // R7
        AST_RD_ONEHOT: assert ($onehot0(rd_hit));            // R7
        AST_OOR_NOHIT: assert (idx_ok || (wr_hit == '0 && rd_hit == '0)); // R7
    end

endmodule

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// One mailbox slot: a stored word and an interrupt flag. A write stores the
// word and sets the flag. A read clears the flag unless a write lands in the
// same cycle, in which case the write takes priority.
// Assumes: wr_hit and rd_hit already qualified by the decoder.
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word_q,
    output logic              flag_q
);

    // Stored word: load on write, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (wr_hit) word_q <= wr_data;
    end

    // Interrupt flag: set by write, cleared by read, write has priority
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (wr_hit) flag_q <= 1'b1;
        else if (rd_hit) flag_q <= 1'b0;
    end

    AST_WR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> flag_q);                                         // R1
    AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> word_q == $past(wr_data));                       // R4
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !wr_hit) |=> !flag_q);                           // R2
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && wr_hit) |=> flag_q);                             // R5
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(word_q));                               // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !rd_hit) |=> $stable(flag_q));                  // R3

endmodule

// File: rtl/mbx_readmux.sv
// Module: mbx_readmux
// Selects the addressed slot's word with an AND-OR tree driven by the
// one-hot read hits, and registers it on a read strobe. An invalid index
// returns zero. The output holds between reads.
// Assumes: rd_hit is one-hot or zero.
module mbx_readmux #(
    parameter int NUM_BOXES = 8,
    parameter int DATA_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_stb,
    input  logic                              idx_ok,
    input  logic [NUM_BOXES-1:0]              rd_hit,
    input  logic [NUM_BOXES-1:0][DATA_W-1:0]  words,
    output logic [DATA_W-1:0]                 rd_data
);

    logic [DATA_W-1:0] sel_word;

    // AND-OR selection of the hit slot's word
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NUM_BOXES; k++) begin
            sel_word = sel_word | (words[k] & {DATA_W{rd_hit[k]}});
        end
    end

    // Output register: load on read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= idx_ok ? sel_word : '0;
    end

    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !idx_ok) |=> rd_data == '0);                    // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));                              // R8

endmodule

// File: rtl/mbx_bank.sv
// Module: mbx_bank
// Top of the write-triggered interrupt mailbox bank. It holds NUM_BOXES
// slots, and each slot has a word and an interrupt line. A write stores the
// word and raises the line. A read returns the word one cycle later and
// acknowledges the line.
// Assumes: synchronous active-low reset; 2**ADDR_W >= NUM_BOXES.
module mbx_bank #(
    parameter int NUM_BOXES = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    acc_idx,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_BOXES-1:0] irq
);

    logic [NUM_BOXES-1:0]             wr_hit;
    logic [NUM_BOXES-1:0]             rd_hit;
    logic                             idx_ok;
    logic [NUM_BOXES-1:0][DATA_W-1:0] words;

    mbx_decode #(.NUM_BOXES(NUM_BOXES), .ADDR_W(ADDR_W)) u_dec (
        .acc_idx (acc_idx),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .idx_ok  (idx_ok)
    );

    for (genvar s = 0; s < NUM_BOXES; s++) begin : g_slot
        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[s]),
            .rd_hit  (rd_hit[s]),
            .wr_data (wr_data),
            .word_q  (words[s]),
            .flag_q  (irq[s])
        );
    end

    mbx_readmux #(.NUM_BOXES(NUM_BOXES), .DATA_W(DATA_W)) u_rmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .idx_ok  (idx_ok),
        .rd_hit  (rd_hit),
        .words   (words),
        .rd_data (rd_data)
    );

    // Port-level rules: reset clears the lines, an invalid index moves no line
    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && rd_data == '0));                   // R6
    AST_OOR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_stb || rd_stb) && !idx_ok) |=> $stable(irq));          // R7

endmodule

// File: tb/mbx_bank_test.sv
`timescale 1ns/1ps
module mbx_bank_test;

    localparam int NB = 8;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] acc_idx = '0;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [NB-1:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mbx_bank #(.NUM_BOXES(NB), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [3:0]    idx;
        logic [31:0]   wdata;
        logic [7:0]    exp_irq;
        logic [31:0]   exp_rd;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'd0,  32'h0,        8'h00, 32'h0,        4'd6}, // R6 idle after reset
        '{1'b1, 1'b0, 4'd3,  32'hA5A50003, 8'h08, 32'h0,        4'd1}, // R1 write raises line 3
        '{1'b0, 1'b1, 4'd3,  32'h0,        8'h00, 32'hA5A50003, 4'd2}, // R2 read returns, acks
        '{1'b0, 1'b0, 4'd0,  32'h0,        8'h00, 32'hA5A50003, 4'd8}, // R8 rd_data holds
        '{1'b1, 1'b0, 4'd0,  32'h11111111, 8'h01, 32'hA5A50003, 4'd1}, // R1 write slot 0
        '{1'b1, 1'b0, 4'd0,  32'h22222222, 8'h01, 32'hA5A50003, 4'd4}, // R4 overwrite
        '{1'b1, 1'b0, 4'd7,  32'h77777777, 8'h81, 32'hA5A50003, 4'd1}, // R1 top slot
        '{1'b0, 1'b1, 4'd0,  32'h0,        8'h80, 32'h22222222, 4'd4}, // R4 last word wins
        '{1'b1, 1'b0, 4'd9,  32'hDEADBEEF, 8'h80, 32'h22222222, 4'd7}, // R7 write ignored
        '{1'b0, 1'b1, 4'd9,  32'h0,        8'h80, 32'h0,        4'd7}, // R7 read zero
        '{1'b0, 1'b1, 4'd3,  32'h0,        8'h80, 32'hA5A50003, 4'd3}, // R3 word kept after read
        '{1'b1, 1'b1, 4'd7,  32'h7A7A7A7A, 8'h80, 32'h77777777, 4'd5}, // R5 write wins
        '{1'b0, 1'b1, 4'd7,  32'h0,        8'h00, 32'h7A7A7A7A, 4'd5}, // R5 new word stored
        '{1'b0, 1'b1, 4'd1,  32'h0,        8'h00, 32'h0,        4'd6}  // R6 untouched slot zero
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic [AW-1:0] i,
                         input logic [DW-1:0] d);
        wr_stb = w; rd_stb = r; acc_idx = i; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6", "irq at reset", 64'(irq), 64'h0);
        check("R6", "rd_data at reset", 64'(rd_data), 64'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].wr, VEC[v].rd, VEC[v].idx, VEC[v].wdata);
            check($sformatf("R%0d", VEC[v].req), $sformatf("vec %0d irq", v),
                  64'(irq), 64'(VEC[v].exp_irq));
            check($sformatf("R%0d", VEC[v].req), $sformatf("vec %0d rd_data", v),
                  64'(rd_data), 64'(VEC[v].exp_rd));
        end

        // R3: two reads in a row return the same word, line stays low
        drive(1'b0, 1'b1, 4'd3, '0);
        drive(1'b0, 1'b1, 4'd3, '0);
        check("R3", "second read word", 64'(rd_data), 64'hA5A50003);
        check("R3", "second read irq", 64'(irq), 64'h0);

        // R7: first invalid index and highest index both ignored
        drive(1'b1, 1'b0, 4'd8, 32'h88888888);
        drive(1'b1, 1'b0, 4'd15, 32'hFFFF0000);
        check("R7", "irq after invalid writes", 64'(irq), 64'h0);
        drive(1'b0, 1'b1, 4'd15, '0);
        check("R7", "read of idx 15", 64'(rd_data), 64'h0);

        // R6: mid-run reset clears a raised line and its stored word
        drive(1'b1, 1'b0, 4'd2, 32'hCAFE0002);
        drive(1'b0, 1'b1, 4'd2, '0);
        drive(1'b1, 1'b0, 4'd2, 32'hCAFE0002);
        check("R1", "line 2 raised", 64'(irq), 64'h04);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6", "irq after reset", 64'(irq), 64'h0);
        check("R6", "rd_data after reset", 64'(rd_data), 64'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 4'd2, '0);
        check("R6", "slot 2 word after reset", 64'(rd_data), 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule